// File: doc/BRIEF.md
# Run-Time Selectable Byte-Stream Narrower

This block takes a streaming interface that delivers 16 bytes per beat and re-emits the same bytes on a 10-lane output. On each output beat it presents only as many bytes as a control input asks for, from 1 to 10. The requested count can differ from one packet to the next while the block is running. Bytes keep their arrival order. The valid bytes of each output beat sit in the lowest lanes. The block drives the output byte-enable mask itself, so it never copies the input mask.

Bytes that are left over from one input beat go into the next output beat. At the end of a packet, the last output beat carries whatever remains and raises the end-of-packet flag. The width setting is captured only between packets, so every beat inside a packet has the same width. Both sides use the usual valid/ready handshake, and either side may stall at any time.

Top module: `strm_narrow`

## Requirements
- R1: Input bytes are taken lowest lane first (lane 0 first). They leave the output in exactly the order they arrived, with none lost and none repeated across input beat boundaries.
- R2: On every valid output beat, m_tkeep is a contiguous run of ones starting at bit 0. Bit i set means output lane i (bits 8i+7..8i of m_tdata) holds a valid byte. The upper lanes are don't-care.
- R3: Every output beat of a packet except the last carries exactly W bytes, where W is the captured width. m_tvalid is high exactly when the buffer holds at least W bytes, or holds a packet's final bytes.
- R4: cfg_width is an unsigned 4-bit count of bytes per beat. The value 0 is treated as 1, and any value above 10 is treated as 10.
- R5: The width is captured from cfg_width only while no packet is in progress. A packet starts with its first accepted input beat and ends with its accepted output beat that has m_tlast set. Changing cfg_width inside a packet has no effect until the next packet.
- R6: The output beat that carries a packet's final byte has m_tlast high. Its m_tkeep marks only the bytes that remain, between 1 and W of them, in the low lanes.
- R7: On an input beat with s_tlast, s_tkeep may mark a shorter low-aligned run (at least one byte). Only the marked bytes are forwarded. On all other input beats s_tkeep is all ones.
- R8: s_tready is high exactly when the buffer holds at most 10 bytes and no final bytes of a packet are still waiting to be sent.
- R9: While m_tvalid is high and m_tready is low, m_tvalid, m_tkeep, m_tlast and the kept bytes of m_tdata stay unchanged.
- R10: A synchronous active-low reset empties the buffer and ends any packet in progress. After reset, m_tvalid is low and s_tready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_width | input | 4 | Requested bytes per output beat |
| s_tdata | input | 128 | Input data, lane 0 in bits 7..0 |
| s_tkeep | input | 16 | Input byte enables |
| s_tlast | input | 1 | Input end of packet |
| s_tvalid | input | 1 | Input beat offered |
| s_tready | output | 1 | Input beat can be taken |
| m_tdata | output | 80 | Output data, valid bytes in the low lanes |
| m_tkeep | output | 10 | Output byte enables, low-aligned |
| m_tlast | output | 1 | Output end of packet |
| m_tvalid | output | 1 | Output beat offered |
| m_tready | input | 1 | Output beat accepted |

## Verification
Appending a new input beat and removing an output beat can happen in the same cycle. The new bytes must then land directly behind the bytes that remain after the shift. The bench provokes this overlap with a random stall pattern on m_tready, with gaps between input beats, and with widths of 1, 3, 7 and 10, so that the buffer level often sits exactly at the acceptance limit. A behavioural byte-queue model judges the outcome every cycle by predicting s_tready, m_tvalid, the byte order and the mask.

// File: rtl/strm_narrow_pkg.sv
package strm_narrow_pkg;

    localparam int unsigned IN_BYTES_DEF  = 16;
    localparam int unsigned OUT_BYTES_DEF = 10;
    localparam int unsigned CFG_W_DEF     = 4;

    // Map a requested byte count onto the legal range 1..max_w.
    function automatic int unsigned clamp_width(int unsigned raw, int unsigned max_w);
        if (raw == 0) begin
            return 1;
        end
        if (raw > max_w) begin
            return max_w;
        end
        return raw;
    endfunction

endpackage

// File: rtl/strm_narrow_wctl.sv
// Holds the per-packet output width; samples the request only between packets.
module strm_narrow_wctl #(
    parameter int unsigned OUT_BYTES = 10,
    parameter int unsigned CFG_W     = 4,
    parameter int unsigned WID_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_width,
    input  logic             pkt_start,
    input  logic             pkt_end,
    output logic [WID_W-1:0] width
);

    typedef struct packed {
        logic             active;
        logic [WID_W-1:0] width;
    } wctl_st_t;

    wctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            st_d.width = WID_W'(strm_narrow_pkg::clamp_width(32'(cfg_width), OUT_BYTES));
        end
        if (pkt_end) begin
            st_d.active = 1'b0;
        end else if (pkt_start) begin
            st_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, width: WID_W'(OUT_BYTES)};
        end else begin
            st_q <= st_d;
        end
    end

    assign width = st_q.width;

endmodule

// File: rtl/strm_narrow_bbuf.sv
// Byte-granular repacking buffer: shift out the front, append behind the rest.
module strm_narrow_bbuf #(
    parameter int unsigned IN_BYTES  = 16,
    parameter int unsigned OUT_BYTES = 10,
    parameter int unsigned BUF_BYTES = 26,
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned WID_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IN_BYTES*8-1:0]  in_data,
    input  logic [IN_BYTES-1:0]    in_keep,
    input  logic                   in_last,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [WID_W-1:0]       width,
    output logic [OUT_BYTES*8-1:0] out_data,
    output logic [OUT_BYTES-1:0]   out_keep,
    output logic                   out_last,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic                   in_fire,
    output logic                   pkt_done
);

    localparam int unsigned ROOM = BUF_BYTES - IN_BYTES;
    localparam int unsigned BI_W = $clog2(BUF_BYTES);
    localparam int unsigned II_W = $clog2(IN_BYTES);

    typedef struct packed {
        logic [BUF_BYTES-1:0][7:0] bytes;
        logic [CNT_W-1:0]          count;
        logic                      tail;
    } bbuf_st_t;

    bbuf_st_t st_d, st_q;

    logic [IN_BYTES-1:0][7:0] in_b;
    int unsigned cnt, wsel, kcnt, n_in, n_out, rem;
    logic out_fire;

    assign in_b = in_data;

    // Output lanes come straight from the front of the buffer.
    for (genvar g = 0; g < OUT_BYTES; g++) begin : g_lane
        assign out_data[g*8 +: 8] = st_q.bytes[g];
        assign out_keep[g]        = (g < kcnt);
    end

    always_comb begin
        cnt  = 32'(st_q.count);
        wsel = 32'(width);
        kcnt = (cnt < wsel) ? cnt : wsel;

        out_valid = (cnt != 0) && ((cnt >= wsel) || st_q.tail);
        out_last  = st_q.tail && (cnt <= wsel);
        in_ready  = !st_q.tail && (cnt <= ROOM);

        out_fire = out_valid && out_ready;
        in_fire  = in_valid && in_ready;

        n_in = 0;
        for (int j = 0; j < IN_BYTES; j++) begin
            if (in_keep[j]) begin
                n_in = n_in + 1;
            end
        end

        n_out = out_fire ? kcnt : 0;
        rem   = cnt - n_out;

        st_d = st_q;
        for (int unsigned i = 0; i < BUF_BYTES; i++) begin
            if (i + n_out < BUF_BYTES) begin
                st_d.bytes[i] = st_q.bytes[BI_W'(i + n_out)];
            end else begin
                st_d.bytes[i] = 8'h00;
            end
            if (in_fire && (i >= rem) && (i < rem + n_in)) begin
                st_d.bytes[i] = in_b[II_W'(i - rem)];
            end
        end

        st_d.count = CNT_W'(rem + (in_fire ? n_in : 0));

        if (out_fire && out_last) begin
            st_d.tail = 1'b0;
        end
        if (in_fire && in_last) begin
            st_d.tail = 1'b1;
        end
        if (st_d.count == '0) begin
            st_d.tail = 1'b0;
        end

        pkt_done = (out_fire && out_last) ||
                   (in_fire && in_last && (st_d.count == '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/strm_narrow.sv
module strm_narrow #(
    parameter int unsigned IN_BYTES  = strm_narrow_pkg::IN_BYTES_DEF,
    parameter int unsigned OUT_BYTES = strm_narrow_pkg::OUT_BYTES_DEF,
    parameter int unsigned CFG_W     = strm_narrow_pkg::CFG_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CFG_W-1:0]       cfg_width,
    input  logic [IN_BYTES*8-1:0]  s_tdata,
    input  logic [IN_BYTES-1:0]    s_tkeep,
    input  logic                   s_tlast,
    input  logic                   s_tvalid,
    output logic                   s_tready,
    output logic [OUT_BYTES*8-1:0] m_tdata,
    output logic [OUT_BYTES-1:0]   m_tkeep,
    output logic                   m_tlast,
    output logic                   m_tvalid,
    input  logic                   m_tready
);

    localparam int unsigned BUF_BYTES = IN_BYTES + OUT_BYTES;
    localparam int unsigned CNT_W     = $clog2(BUF_BYTES + 1);
    localparam int unsigned WID_W     = $clog2(OUT_BYTES + 1);

    logic [WID_W-1:0] width;
    logic             in_fire;
    logic             pkt_done;

    strm_narrow_wctl #(
        .OUT_BYTES (OUT_BYTES),
        .CFG_W     (CFG_W),
        .WID_W     (WID_W)
    ) u_wctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_width (cfg_width),
        .pkt_start (in_fire),
        .pkt_end   (pkt_done),
        .width     (width)
    );

    strm_narrow_bbuf #(
        .IN_BYTES  (IN_BYTES),
        .OUT_BYTES (OUT_BYTES),
        .BUF_BYTES (BUF_BYTES),
        .CNT_W     (CNT_W),
        .WID_W     (WID_W)
    ) u_bbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (s_tdata),
        .in_keep   (s_tkeep),
        .in_last   (s_tlast),
        .in_valid  (s_tvalid),
        .in_ready  (s_tready),
        .width     (width),
        .out_data  (m_tdata),
        .out_keep  (m_tkeep),
        .out_last  (m_tlast),
        .out_valid (m_tvalid),
        .out_ready (m_tready),
        .in_fire   (in_fire),
        .pkt_done  (pkt_done)
    );

endmodule

// File: rtl/strm_narrow_chk.sv
module strm_narrow_chk #(
    parameter int unsigned OUT_BYTES = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   s_tvalid,
    input logic                   s_tready,
    input logic                   s_tlast,
    input logic                   s_keep0,
    input logic                   m_tvalid,
    input logic                   m_tready,
    input logic                   m_tlast,
    input logic [OUT_BYTES-1:0]   m_tkeep,
    input logic [OUT_BYTES*8-1:0] m_tdata
);

    logic [OUT_BYTES*8-1:0] kept_data;
    logic                   tail_q;
    logic                   have_q;
    logic [OUT_BYTES-1:0]   keep_q;

    always_comb begin
        for (int i = 0; i < OUT_BYTES; i++) begin
            kept_data[i*8 +: 8] = m_tkeep[i] ? m_tdata[i*8 +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= 1'b0;
            have_q <= 1'b0;
            keep_q <= '0;
        end else begin
            if (s_tvalid && s_tready && s_tlast && s_keep0) begin
                tail_q <= 1'b1;
            end else if (m_tvalid && m_tready && m_tlast) begin
                tail_q <= 1'b0;
            end
            if (m_tvalid && m_tready) begin
                have_q <= !m_tlast;
                keep_q <= m_tkeep;
            end
        end
    end

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tkeep) &&
                                     $stable(m_tlast) && $stable(kept_data)));

    // R2
    keep_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> ((m_tkeep & (m_tkeep + OUT_BYTES'(1))) == '0));

    // R2
    keep_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> m_tkeep[0]);

    // R8
    tail_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_q |-> !s_tready);

    // R3
    keep_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && m_tvalid && !m_tlast) |-> (m_tkeep == keep_q));

    // R6
    last_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && m_tvalid && m_tlast) |-> ($countones(m_tkeep) <= $countones(keep_q)));

endmodule

bind strm_narrow strm_narrow_chk #(.OUT_BYTES(OUT_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .s_tlast  (s_tlast),
    .s_keep0  (s_tkeep[0]),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast),
    .m_tkeep  (m_tkeep),
    .m_tdata  (m_tdata)
);

// File: tb/test_strm_narrow.sv
`timescale 1ns/1ps
module test_strm_narrow;

    localparam int IN   = 16;
    localparam int OUT  = 10;
    localparam int ROOM = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [3:0]      cfg_width;
    logic [IN*8-1:0] s_tdata;
    logic [IN-1:0]   s_tkeep;
    logic            s_tlast, s_tvalid, s_tready;
    logic [OUT*8-1:0] m_tdata;
    logic [OUT-1:0]  m_tkeep;
    logic            m_tlast, m_tvalid;
    logic            m_tready = 1'b0;

    always #4 clk = ~clk;

    strm_narrow i_strm_narrow (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    int    checks = 0;
    int    fails  = 0;
    int    bq[$];          // bytes in flight; value > 255 marks a packet's final byte
    int    wq[$];          // captured width per packet
    bit    in_pkt = 1'b0;
    int    ready_mode = 0; // 0 always ready, 1 random, 2 never
    int    nextb = 0;
    string tag = "R3";
    bit    done = 1'b0;
    int    cyc = 0;

    bit              pv = 1'b0, pr = 1'b0, pl = 1'b0;
    logic [OUT-1:0]  pk;
    logic [OUT*8-1:0] pd;

    function automatic int clampw(int c);
        if (c == 0) return 1;
        if (c > OUT) return OUT;
        return c;
    endfunction

    function automatic logic [OUT-1:0] lowmask(int n);
        logic [OUT-1:0] m;
        for (int k = 0; k < OUT; k++) m[k] = (k < n);
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0:       m_tready = 1'b1;
            1:       m_tready = 1'($urandom % 2);
            default: m_tready = 1'b0;
        endcase
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    // Reference model, compared on every clock.
    always @(negedge clk) begin : mon
        int  cnt, w, n, nin;
        bit  tail, lst, ok, expv;
        logic [OUT*8-1:0] md;
        if (!rst_n) begin
            bq.delete();
            wq.delete();
            in_pkt = 1'b0;
            pv = 1'b0;
        end else begin
            cnt  = bq.size();
            tail = 1'b0;
            for (int k = 0; k < cnt; k++) if (bq[k] > 255) tail = 1'b1;
            w = (wq.size() > 0) ? wq[0] : OUT;
            for (int k = 0; k < OUT; k++) md[k*8 +: 8] = m_tkeep[k] ? m_tdata[k*8 +: 8] : 8'h00;

            chk(s_tready == (!tail && cnt <= ROOM), "R8", "s_tready", int'(s_tready),
                int'(!tail && cnt <= ROOM));
            expv = (cnt > 0) && (cnt >= w || tail);
            chk(m_tvalid == expv, "R3", "m_tvalid", int'(m_tvalid), int'(expv));

            if (pv && !pr) begin
                chk(m_tvalid && m_tkeep == pk && m_tlast == pl && md == pd, "R9",
                    "held beat keep", int'(m_tkeep), int'(pk));
            end

            if (m_tvalid && m_tready) begin
                n = 0;
                lst = 1'b0;
                for (int k = 0; k < w && k < cnt; k++) begin
                    n++;
                    if (bq[k] > 255) begin
                        lst = 1'b1;
                        break;
                    end
                end
                chk((m_tkeep & (m_tkeep + 10'd1)) == '0, "R2", "keep shape",
                    int'(m_tkeep), int'(lowmask(n)));
                chk(m_tkeep == lowmask(n), lst ? "R6" : tag, "keep",
                    int'(m_tkeep), int'(lowmask(n)));
                chk(m_tlast == lst, "R6", "tlast", int'(m_tlast), int'(lst));
                ok = 1'b1;
                for (int k = 0; k < n; k++) begin
                    if (int'(m_tdata[k*8 +: 8]) != (bq[k] & 255)) ok = 1'b0;
                end
                chk(ok, "R1", "byte order lane0", int'(m_tdata[7:0]),
                    (n > 0) ? (bq[0] & 255) : 0);
                for (int k = 0; k < n; k++) void'(bq.pop_front());
                if (lst && wq.size() > 0) void'(wq.pop_front());
            end

            if (s_tvalid && s_tready) begin
                if (!in_pkt) wq.push_back(clampw(int'(cfg_width)));
                nin = 0;
                for (int k = 0; k < IN; k++) if (s_tkeep[k]) nin++;
                for (int k = 0; k < nin; k++) begin
                    bq.push_back(int'(s_tdata[k*8 +: 8]) +
                                 ((s_tlast && k == nin - 1) ? 256 : 0));
                end
                in_pkt = !s_tlast;
            end

            pv = m_tvalid;
            pr = m_tready;
            pk = m_tkeep;
            pl = m_tlast;
            pd = md;
        end
    end

    task automatic handshake();
        do @(negedge clk); while (!s_tready);
        @(posedge clk);
        #1;
    endtask

    task automatic send_pkt(input int nbytes, input int cfg, input int cfg2, input bit gaps);
        int sent = 0;
        bit first = 1'b1;
        cfg_width = 4'(cfg);
        while (sent < nbytes) begin
            int n = (nbytes - sent > IN) ? IN : nbytes - sent;
            for (int k = 0; k < IN; k++)
                s_tdata[k*8 +: 8] = (k < n) ? 8'((nextb + k) & 255) : 8'hEE;
            for (int k = 0; k < IN; k++) s_tkeep[k] = (k < n);
            s_tlast  = (sent + n == nbytes);
            s_tvalid = 1'b1;
            handshake();
            nextb += n;
            sent  += n;
            if (first) cfg_width = 4'(cfg2);
            first = 1'b0;
            s_tvalid = 1'b0;
            if (gaps) repeat ($urandom % 3) @(posedge clk);
            if (gaps) #1;
        end
        s_tvalid = 1'b0;
    endtask

    task automatic drain();
        while (bq.size() != 0) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0;
        s_tvalid = 1'b0;
        s_tdata = '0;
        s_tkeep = '0;
        s_tlast = 1'b0;
        cfg_width = 4'd3;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R10", "m_tvalid after reset", int'(m_tvalid), 0);
        chk(s_tready == 1'b1, "R10", "s_tready after reset", int'(s_tready), 1);
        @(posedge clk);
        #1;

        // width 3, free-running output
        send_pkt(40, 3, 3, 1'b0);
        drain();
        // width 1 under random stalls
        ready_mode = 1;
        send_pkt(20, 1, 1, 1'b1);
        // width 10, partial final input beat (R7)
        tag = "R7";
        send_pkt(50, 10, 10, 1'b1);
        send_pkt(17, 6, 6, 1'b0);
        drain();
        // clamping (R4)
        tag = "R4";
        send_pkt(5, 0, 0, 1'b0);
        send_pkt(33, 15, 15, 1'b1);
        drain();
        // width change inside a packet is deferred (R5)
        tag = "R5";
        send_pkt(45, 4, 7, 1'b1);
        send_pkt(30, 7, 7, 1'b0);
        drain();
        // back-to-back single-beat packets
        tag = "R3";
        ready_mode = 0;
        repeat (3) send_pkt(16, 7, 7, 1'b0);
        ready_mode = 1;
        send_pkt(64, 9, 2, 1'b1);
        drain();

        // reset with bytes held inside (R10)
        ready_mode = 2;
        @(posedge clk);
        #1;
        cfg_width = 4'd5;
        for (int k = 0; k < IN; k++) s_tdata[k*8 +: 8] = 8'((nextb + k) & 255);
        nextb += IN;
        s_tkeep = '1;
        s_tlast = 1'b0;
        s_tvalid = 1'b1;
        handshake();
        s_tvalid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R10", "m_tvalid after mid-run reset", int'(m_tvalid), 0);
        chk(s_tready == 1'b1, "R10", "s_tready after mid-run reset", int'(s_tready), 1);
        @(posedge clk);
        #1;
        ready_mode = 0;
        send_pkt(12, 5, 5, 1'b0);
        drain();
        repeat (4) @(posedge clk);

        summary();
        $finish;
    end

endmodule